// File: doc/BRIEF.md
# Linked-List DMA Descriptor Loader

This block is the chaining front end of a single DMA channel. Software programs a configuration word and, for chained operation, the address of the first record. The loader then reads a nine-word channel record from memory, one word at a time, into the channel's working registers. It starts an external transfer engine through a start/done handshake. When the transfer is done, it takes the next record's address from the link word of the current record and repeats. It stops after the record whose fragment-length word carries the last-node flag.

When chaining is off, one transfer runs from working registers that software has written directly, and no memory read takes place. Two conditions raise a sticky error and halt the loader until reset: a memory read that returns an error, and a chained start with a zero first-record pointer. Clearing the channel enable while the loader is busy abandons the chain. The abort takes effect when the word fetch or transfer in progress completes.

Top module: `lldma_loader`

## Requirements
- R1: After reset, cfg_q is 0 and busy, mrd_req, xfer_start, chain_done and err_flag are all 0.
- R2: Register map, selected by reg_addr on a reg_we cycle. Address 0 is the configuration word: bit 0 is the channel enable, bit 4 turns on chaining, and bit 24 set means the engine need not wait for block-done. Address 1 is the first-record pointer. Addresses 2 to 10 are working words 0 to 8. If a configuration write with bit 0 set arrives while idle and bit 4 is clear, the loader issues exactly one xfer_start using the programmed working words and performs no memory read. When xfer_done arrives, it pulses chain_done and clears bit 0.
- R3: If a configuration write with bits 0 and 4 set arrives while idle and the pointer P is nonzero, the loader reads the nine record words from P, P+4, ..., P+32 in that order, with one request at a time. It then pulses xfer_start, and at that moment working words 0 to 8 equal the words read. The word order is source address, destination address, fragment length with flags, block length, transfer step, link pointer, fragment step, source block step, destination block step.
- R4: After xfer_done for a record whose word 2 has bit 19 clear, the loader fetches the next record starting at the address held in that record's working word 5.
- R5: After xfer_done for a record whose word 2 has bit 19 set, the loader pulses chain_done for one cycle and clears enable bit 0. It issues no further read, even though that record's link pointer is valid and wraps back to the first record.
- R6: xfer_no_wait follows bit 24 of the configuration word.
- R7: A read response with mrd_rerr set makes err_flag 1 and clears enable bit 0. The flag stays set until reset, and the loader issues no further reads or starts, including for later start writes.
- R8: A chained start while the first-record pointer is 0 sets err_flag and clears enable bit 0, with no memory read.
- R9: A configuration write with bit 0 clear during a fetch returns the loader to idle after the response in flight, with no further reads, no xfer_start and no chain_done. The same write during a transfer returns the loader to idle after xfer_done, with no further read and no chain_done.
- R10: Writes to the working words or to the pointer while the loader is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| cfg_q | output | 32 | Current configuration word |
| mrd_req | output | 1 | Read request, held until its response |
| mrd_addr | output | 32 | Read byte address |
| mrd_rvalid | input | 1 | Read response valid |
| mrd_rdata | input | 32 | Read response data |
| mrd_rerr | input | 1 | Read response error |
| xfer_start | output | 1 | One-cycle transfer start |
| xfer_no_wait | output | 1 | Block-done wait bypass to the engine |
| xfer_done | input | 1 | Transfer completion pulse |
| wk_words | output | 288 | Working words, word i in bits 32i+31:32i |
| busy | output | 1 | Fetching, starting or transferring |
| chain_done | output | 1 | One-cycle end-of-chain pulse |
| err_flag | output | 1 | Sticky error |

## Verification
The assertions assume well-behaved neighbours. The memory raises mrd_rvalid only while mrd_req is high, once per request. The engine gives a single xfer_done for each xfer_start, after at least one cycle. The bench's memory responder waits for a pending request, adds zero to three idle cycles, and answers once with a one-cycle pulse. The engine model answers each start once, after one to four cycles, or after ten cycles in the abort case, so both neighbours stay inside those assumptions.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned NUM_WORDS  = 9;
  localparam int unsigned IDX_W      = $clog2(NUM_WORDS + 1);
  localparam int unsigned REG_AW     = 4;
  localparam int unsigned BYTES_PER  = DATA_W / 8;
  localparam int unsigned FRAG_IDX   = 2;
  localparam int unsigned LINK_IDX   = 5;
  localparam int unsigned LAST_BIT   = 19;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned CHAIN_BIT  = 4;
  localparam int unsigned NOWAIT_BIT = 24;
  localparam int unsigned REG_CFG    = 0;
  localparam int unsigned REG_PTR    = 1;
  localparam int unsigned REG_WK     = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_START, ST_RUN, ST_HALT
  } ld_state_t;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return base + ADDR_W'(idx) * ADDR_W'(BYTES_PER);
  endfunction

  function automatic logic is_last(input logic [DATA_W-1:0] frag);
    return frag[LAST_BIT];
  endfunction

  function automatic logic is_work_addr(input logic [REG_AW-1:0] a);
    return (32'(a) >= REG_WK) && (32'(a) < REG_WK + NUM_WORDS);
  endfunction
endpackage

// File: rtl/lldma_cfg_regs.sv
module lldma_cfg_regs
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              ptr_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hw_clr_en,
  output logic [DATA_W-1:0] cfg_q,
  output logic [ADDR_W-1:0] ptr_q
);
  logic [DATA_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = wdata;
    if (hw_clr_en) cfg_d[EN_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ptr_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      if (ptr_we) ptr_q <= ADDR_W'(wdata);
    end
  end
endmodule

// File: rtl/lldma_work_regs.sv
module lldma_work_regs
  import lldma_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sw_we,
  input  logic [IDX_W-1:0]            sw_idx,
  input  logic [DATA_W-1:0]           sw_data,
  input  logic                        hw_we,
  input  logic [IDX_W-1:0]            hw_idx,
  input  logic [DATA_W-1:0]           hw_data,
  output logic [NUM_WORDS*DATA_W-1:0] words
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                w_q <= '0;
      else if (hw_we && hw_idx == IDX_W'(g))     w_q <= hw_data;
      else if (sw_we && sw_idx == IDX_W'(g))     w_q <= sw_data;
    end
    assign words[g*DATA_W +: DATA_W] = w_q;
  end
endmodule

// File: rtl/lldma_fetch.sv
module lldma_fetch
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_val,
  input  logic              active,
  input  logic              rvalid,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              word_take,
  output logic              fetch_last
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;

  assign word_take  = active && rvalid;
  assign fetch_last = (idx_q == IDX_W'(NUM_WORDS - 1));
  assign addr       = word_addr(base_q, idx_q);
  assign idx        = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (ptr_load) begin
      base_q <= ptr_val;
      idx_q  <= '0;
    end else if (word_take && !fetch_last) begin
      idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_start,
  input  logic              start_chain,
  input  logic              chan_en,
  input  logic              chain_mode,
  input  logic [ADDR_W-1:0] first_ptr,
  input  logic              rvalid,
  input  logic              rerr,
  input  logic              fetch_last,
  input  logic              xfer_done,
  input  logic              frag_last,
  input  logic [ADDR_W-1:0] next_link,
  output logic              ptr_load,
  output logic [ADDR_W-1:0] ptr_val,
  output logic              fetch_active,
  output logic              fill_we,
  output logic              hw_clr_en,
  output logic              xfer_start,
  output logic              idle,
  output logic              busy,
  output logic              chain_end,
  output logic              err_set,
  output logic              chain_done,
  output logic              err_flag
);
  ld_state_t state_q, state_d;

  always_comb begin
    state_d   = state_q;
    ptr_load  = 1'b0;
    ptr_val   = first_ptr;
    fill_we   = 1'b0;
    chain_end = 1'b0;
    err_set   = 1'b0;
    case (state_q)
      ST_IDLE: if (sw_start) begin
        if (!start_chain)            state_d = ST_START;
        else if (first_ptr == '0) begin
          err_set = 1'b1;
          state_d = ST_HALT;
        end else begin
          ptr_load = 1'b1;
          state_d  = ST_FETCH;
        end
      end
      ST_FETCH: if (rvalid) begin
        if (rerr) begin
          err_set = 1'b1;
          state_d = ST_HALT;
        end else if (!chan_en) begin
          state_d = ST_IDLE;
        end else begin
          fill_we = 1'b1;
          if (fetch_last) state_d = ST_START;
        end
      end
      ST_START: state_d = ST_RUN;
      ST_RUN: if (xfer_done) begin
        if (!chan_en) begin
          state_d = ST_IDLE;
        end else if (!chain_mode || frag_last) begin
          chain_end = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          ptr_load = 1'b1;
          ptr_val  = next_link;
          state_d  = ST_FETCH;
        end
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_IDLE;
    endcase
  end

  assign hw_clr_en    = chain_end || err_set;
  assign fetch_active = (state_q == ST_FETCH);
  assign xfer_start   = (state_q == ST_START);
  assign idle         = (state_q == ST_IDLE);
  assign busy         = (state_q == ST_FETCH) || (state_q == ST_START) ||
                        (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      chain_done <= 1'b0;
      err_flag   <= 1'b0;
    end else begin
      state_q    <= state_d;
      chain_done <= chain_end;
      err_flag   <= err_flag || err_set;
    end
  end
endmodule

// File: rtl/lldma_loader.sv
module lldma_loader
  import lldma_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [REG_AW-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           cfg_q,
  output logic                        mrd_req,
  output logic [ADDR_W-1:0]           mrd_addr,
  input  logic                        mrd_rvalid,
  input  logic [DATA_W-1:0]           mrd_rdata,
  input  logic                        mrd_rerr,
  output logic                        xfer_start,
  output logic                        xfer_no_wait,
  input  logic                        xfer_done,
  output logic [NUM_WORDS*DATA_W-1:0] wk_words,
  output logic                        busy,
  output logic                        chain_done,
  output logic                        err_flag
);
  logic              cfg_we, ptr_we, sw_start, wk_sw_we, idle;
  logic              ptr_load, fetch_active, fill_we, hw_clr_en;
  logic              word_take, fetch_last, chain_end, err_set;
  logic [ADDR_W-1:0] ptr_q, ptr_val;
  logic [IDX_W-1:0]  fetch_idx;
  logic [IDX_W-1:0]  sw_idx;

  assign cfg_we   = reg_we && (32'(reg_addr) == REG_CFG);
  assign ptr_we   = reg_we && (32'(reg_addr) == REG_PTR) && idle;
  assign wk_sw_we = reg_we && is_work_addr(reg_addr) && idle;
  assign sw_idx   = IDX_W'(reg_addr - REG_AW'(REG_WK));
  assign sw_start = cfg_we && reg_wdata[EN_BIT];

  assign mrd_req      = fetch_active;
  assign xfer_no_wait = cfg_q[NOWAIT_BIT];

  lldma_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .ptr_we(ptr_we),
    .wdata(reg_wdata), .hw_clr_en(hw_clr_en), .cfg_q(cfg_q), .ptr_q(ptr_q)
  );

  lldma_work_regs u_work (
    .clk(clk), .rst_n(rst_n), .sw_we(wk_sw_we), .sw_idx(sw_idx),
    .sw_data(reg_wdata), .hw_we(fill_we), .hw_idx(fetch_idx),
    .hw_data(mrd_rdata), .words(wk_words)
  );

  lldma_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .active(fetch_active), .rvalid(mrd_rvalid), .addr(mrd_addr),
    .idx(fetch_idx), .word_take(word_take), .fetch_last(fetch_last)
  );

  lldma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start),
    .start_chain(reg_wdata[CHAIN_BIT]), .chan_en(cfg_q[EN_BIT]),
    .chain_mode(cfg_q[CHAIN_BIT]), .first_ptr(ptr_q),
    .rvalid(mrd_rvalid), .rerr(mrd_rerr), .fetch_last(fetch_last),
    .xfer_done(xfer_done),
    .frag_last(is_last(wk_words[FRAG_IDX*DATA_W +: DATA_W])),
    .next_link(ADDR_W'(wk_words[LINK_IDX*DATA_W +: DATA_W])),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .fetch_active(fetch_active),
    .fill_we(fill_we), .hw_clr_en(hw_clr_en), .xfer_start(xfer_start),
    .idle(idle), .busy(busy), .chain_end(chain_end), .err_set(err_set),
    .chain_done(chain_done), .err_flag(err_flag)
  );
endmodule

// File: rtl/lldma_loader_chk.sv
module lldma_loader_chk
  import lldma_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mrd_req,
  input logic [ADDR_W-1:0] mrd_addr,
  input logic              mrd_rvalid,
  input logic              xfer_start,
  input logic              chain_done,
  input logic              err_flag,
  input logic [DATA_W-1:0] cfg_q,
  input logic              busy,
  input logic              word_take,
  input logic              fetch_last
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_req && !mrd_rvalid |=> mrd_req && $stable(mrd_addr));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_take && !fetch_last |=> !mrd_req ||
      (mrd_addr == $past(mrd_addr) + ADDR_W'(BYTES_PER)));

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  p_done_clears_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !cfg_q[EN_BIT]);

  p_no_fetch_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !mrd_req && !busy);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> !chain_done);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> !mrd_req && !xfer_start && !busy);
endmodule

bind lldma_loader lldma_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mrd_req(mrd_req), .mrd_addr(mrd_addr),
  .mrd_rvalid(mrd_rvalid), .xfer_start(xfer_start), .chain_done(chain_done),
  .err_flag(err_flag), .cfg_q(cfg_q), .busy(busy), .word_take(word_take),
  .fetch_last(fetch_last)
);

// File: tb/lldma_loader_tb.sv
`timescale 1ns/1ps
module lldma_loader_tb;
  import lldma_pkg::*;
  localparam int WW = NUM_WORDS * DATA_W;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] cfg_q, mrd_addr, mrd_rdata = '0;
  logic mrd_req, mrd_rvalid = 0, mrd_rerr = 0;
  logic xfer_start, xfer_no_wait, xfer_done = 0;
  logic [WW-1:0] wk_words;
  logic busy, chain_done, err_flag;

  always #2 clk = ~clk;

  lldma_loader u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cfg_q(cfg_q), .mrd_req(mrd_req),
    .mrd_addr(mrd_addr), .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
    .mrd_rerr(mrd_rerr), .xfer_start(xfer_start), .xfer_no_wait(xfer_no_wait),
    .xfer_done(xfer_done), .wk_words(wk_words), .busy(busy),
    .chain_done(chain_done), .err_flag(err_flag)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:511];
  int rd_cnt = 0, st_cnt = 0, cd_cnt = 0;
  logic [WW-1:0] st_log [0:31];
  bit eng_slow = 0, err_en = 0;
  logic [31:0] err_addr = '0;
  int ch_bw, ch_n;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rec_addr(input int bw, input int k, input int j);
    return 32'(bw * 4 + k * 40 + 4 + 4 * j);
  endfunction

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mrd_rvalid) begin
        mrd_rvalid = 0;
        mrd_rerr = 0;
      end else if (mrd_req) begin
        repeat ($urandom_range(0, 3)) @(negedge clk);
        if (mrd_req) begin
          mrd_rdata = mem[mrd_addr[9:2]];
          mrd_rerr = err_en && (mrd_addr == err_addr);
          mrd_rvalid = 1;
          rd_log[rd_cnt % 512] = mrd_addr;
          rd_cnt++;
        end
      end
    end
  end

  // transfer engine
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_start) begin
        st_log[st_cnt % 32] = wk_words;
        st_cnt++;
        repeat (eng_slow ? 10 : $urandom_range(1, 4)) @(negedge clk);
        xfer_done = 1;
        @(negedge clk);
        xfer_done = 0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (chain_done) cd_cnt++;
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(negedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = REG_AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_cd(input int b);
    for (int i = 0; i < 3000 && cd_cnt <= b; i++) @(negedge clk);
  endtask

  task automatic build(input int n);
    ch_n = n;
    ch_bw = $urandom_range(0, 150);
    for (int k = 0; k < n; k++) begin
      mem[ch_bw + 10 * k] = $urandom;
      for (int j = 0; j < NUM_WORDS; j++) begin
        logic [31:0] v;
        v = $urandom;
        if (j == FRAG_IDX) begin
          v[LAST_BIT] = (k == n - 1);
        end
        if (j == LINK_IDX) v = rec_addr(ch_bw, (k + 1) % n, 0);
        mem[ch_bw + 10 * k + 1 + j] = v;
      end
    end
  endtask

  initial begin
    int r0, s0, c0, k0;
    logic [WW-1:0] w, prog;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    do_reset();

    // R1 reset state
    chk("R1 cfg", cfg_q, 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 req", 32'(mrd_req), 0);
    chk("R1 start", 32'(xfer_start), 0);
    chk("R1 done", 32'(chain_done), 0);
    chk("R1 err", 32'(err_flag), 0);

    // R2 direct single transfer, R6 no-wait bit
    for (int j = 0; j < NUM_WORDS; j++) begin
      prog[j*32 +: 32] = $urandom;
      wr(REG_WK + j, prog[j*32 +: 32]);
    end
    r0 = rd_cnt; s0 = st_cnt; c0 = cd_cnt;
    wr(REG_CFG, 32'h0100_0001);
    chk("R6 nowait set", 32'(xfer_no_wait), 1);
    wait_cd(c0);
    repeat (3) @(negedge clk);
    chk("R2 reads", 32'(rd_cnt - r0), 0);
    chk("R2 starts", 32'(st_cnt - s0), 1);
    for (int j = 0; j < NUM_WORDS; j++)
      chk("R2 word", st_log[s0 % 32][j*32 +: 32], prog[j*32 +: 32]);
    chk("R2 done", 32'(cd_cnt - c0), 1);
    chk("R2 en cleared", 32'(cfg_q[0]), 0);

    // R3 R4 R5 random chains
    for (int it = 0; it < 3; it++) begin
      build($urandom_range(2, 4));
      wr(REG_PTR, rec_addr(ch_bw, 0, 0));
      r0 = rd_cnt; s0 = st_cnt; c0 = cd_cnt;
      wr(REG_CFG, 32'h0000_0011);
      chk("R6 nowait clear", 32'(xfer_no_wait), 0);
      wait_cd(c0);
      repeat (20) @(negedge clk);
      chk("R5 read count", 32'(rd_cnt - r0), 32'(9 * ch_n));
      for (int k = 0; k < ch_n; k++)
        for (int j = 0; j < NUM_WORDS; j++)
          chk(k == 0 ? "R3 addr" : "R4 addr", rd_log[(r0 + 9 * k + j) % 512],
              rec_addr(ch_bw, k, j));
      chk("R5 starts", 32'(st_cnt - s0), 32'(ch_n));
      for (int k = 0; k < ch_n; k++)
        for (int j = 0; j < NUM_WORDS; j++)
          chk("R3 word", st_log[(s0 + k) % 32][j*32 +: 32],
              mem[ch_bw + 10 * k + 1 + j]);
      chk("R5 done", 32'(cd_cnt - c0), 1);
      chk("R5 en cleared", 32'(cfg_q[0]), 0);
      chk("R5 idle", 32'(busy), 0);
    end

    // R9 abort during fetch
    build(3);
    wr(REG_PTR, rec_addr(ch_bw, 0, 0));
    r0 = rd_cnt; s0 = st_cnt; c0 = cd_cnt;
    wr(REG_CFG, 32'h0000_0011);
    for (int i = 0; i < 200 && rd_cnt < r0 + 3; i++) @(negedge clk);
    k0 = rd_cnt;
    wr(REG_CFG, 32'h0000_0010);
    repeat (30) @(negedge clk);
    chk("R9 fetch abort reads", 32'(rd_cnt - k0 <= 1), 1);
    chk("R9 fetch abort starts", 32'(st_cnt - s0), 0);
    chk("R9 fetch abort done", 32'(cd_cnt - c0), 0);
    chk("R9 fetch abort idle", 32'(busy), 0);

    // R9 abort during transfer, R10 writes while busy
    eng_slow = 1;
    build(2);
    wr(REG_PTR, rec_addr(ch_bw, 0, 0));
    r0 = rd_cnt; s0 = st_cnt; c0 = cd_cnt;
    wr(REG_CFG, 32'h0000_0011);
    for (int i = 0; i < 300 && st_cnt == s0; i++) @(negedge clk);
    w = wk_words;
    wr(REG_WK, ~w[31:0]);
    wr(REG_WK + LINK_IDX, 32'h0000_0000);
    chk("R10 word0 kept", wk_words[31:0], w[31:0]);
    chk("R10 link kept", wk_words[LINK_IDX*32 +: 32], w[LINK_IDX*32 +: 32]);
    wr(REG_CFG, 32'h0000_0010);
    repeat (40) @(negedge clk);
    eng_slow = 0;
    chk("R9 xfer abort reads", 32'(rd_cnt - r0), 9);
    chk("R9 xfer abort starts", 32'(st_cnt - s0), 1);
    chk("R9 xfer abort done", 32'(cd_cnt - c0), 0);
    chk("R9 xfer abort idle", 32'(busy), 0);

    // R8 zero pointer
    wr(REG_PTR, 32'h0);
    r0 = rd_cnt;
    wr(REG_CFG, 32'h0000_0011);
    chk("R8 err", 32'(err_flag), 1);
    chk("R8 en cleared", 32'(cfg_q[0]), 0);
    repeat (10) @(negedge clk);
    chk("R8 no reads", 32'(rd_cnt - r0), 0);
    chk("R8 idle", 32'(busy), 0);
    do_reset();
    chk("R1 err after reset", 32'(err_flag), 0);

    // R7 read error on the second word
    build(2);
    err_addr = rec_addr(ch_bw, 0, 1);
    err_en = 1;
    wr(REG_PTR, rec_addr(ch_bw, 0, 0));
    r0 = rd_cnt; s0 = st_cnt;
    wr(REG_CFG, 32'h0000_0011);
    repeat (30) @(negedge clk);
    chk("R7 err", 32'(err_flag), 1);
    chk("R7 reads", 32'(rd_cnt - r0), 2);
    chk("R7 starts", 32'(st_cnt - s0), 0);
    chk("R7 en cleared", 32'(cfg_q[0]), 0);
    err_en = 0;
    wr(REG_CFG, 32'h0000_0011);
    repeat (20) @(negedge clk);
    chk("R7 still halted reads", 32'(rd_cnt - r0), 2);
    chk("R7 still halted starts", 32'(st_cnt - s0), 0);
    chk("R7 sticky", 32'(err_flag), 1);
    do_reset();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule